// File: doc/BRIEF.md
# Multi-Task Heartbeat Aggregator

This block supervises several monitored tasks at once. Each task sends a one-cycle alive strobe whenever it completes a pass of its main loop. The strobes are collected in a sticky bitmask, with one bit per task. A periodic check tick arrives from a slow timebase, nominally every 100 ms.

On each tick the block compares the collected bits against the set of enabled tasks.

- **All enabled tasks reported.** The block sends a one-cycle feed pulse to a downstream watchdog timer and starts a fresh collection period.
- **Any enabled task missing.** The block withholds the feed and keeps the collected bits. It latches which enabled tasks were silent and bumps a saturating miss counter.

A single stuck task therefore starves the watchdog even while every other task keeps running.

The control core is a three-state machine:

- `ST_COLLECT` is the idle collection state.
- `ST_FEED` is held for exactly one cycle after a passing check.
- `ST_MISS` is held for exactly one cycle after a failing check.

The transitions are:

- **check_pass:** a tick with every enabled bit set moves any state to `ST_FEED`.
- **check_fail:** a tick with an enabled bit clear moves any state to `ST_MISS`.
- **settle:** no tick returns `ST_FEED` or `ST_MISS` to `ST_COLLECT`.
- **wait:** no tick keeps `ST_COLLECT` in `ST_COLLECT`.

Top module: `hb_aggregator`

## Requirements
- R1: After reset `feed_o` is 0, `missing_o` is all zeros and `miss_count_o` is 0.
- R2: Alive strobes accumulate by OR: strobes from different tasks in different cycles of one period all count toward the next check.
- R3: A tick whose collected mask covers every enabled task makes `feed_o` high for exactly one cycle, the cycle after the tick (state `ST_FEED`).
- R4: After a passing check the collected mask is cleared, so a following tick with no new strobes fails.
- R5: A failing check raises no feed and keeps the collected mask; a later strobe from the missing task alone then lets the next tick pass.
- R6: A strobe in the same cycle as a passing tick is not used for that check but is kept in the new period.
- R7: On a failing check `missing_o` takes the enabled tasks whose bit is clear (bit i = task i), one cycle after the tick, and holds it until the next check. A passing check clears it.
- R8: Tasks whose `enable_i` bit is 0 are ignored by the check; with no task enabled every tick feeds.
- R9: Each failing check increments `miss_count_o` by one, saturating at 2^MISS_W-1.
- R10: Without a tick the state machine rests in `ST_COLLECT` and `feed_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alive_i | input | NUM_TASKS | One-cycle alive strobe per task |
| enable_i | input | NUM_TASKS | Per-task monitoring enable |
| tick_i | input | 1 | Periodic check request, one cycle wide |
| feed_o | output | 1 | One-cycle feed pulse to the watchdog |
| missing_o | output | NUM_TASKS | Tasks absent at the last failing check |
| miss_count_o | output | MISS_W | Saturating count of failing checks |

## Verification
The assertions take `tick_i` to be a one-cycle request. They also take `enable_i` to be stable around a tick, so that the expected missing vector is well defined.

The stimulus only changes the enable mask in idle cycles, well away from a tick. It raises the tick for a single cycle at a time, except in the deliberate back-to-back tick runs used for saturation. Alive strobes are driven freely, including in the tick cycle itself, to reach the carry-over case.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_FEED    = 2'd1,
        ST_MISS    = 2'd2
    } hb_state_e;
endpackage

// File: rtl/hb_mask_accum.sv
module hb_mask_accum #(
    parameter int NUM_TASKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TASKS-1:0] alive_i,
    input  logic                 clear_i,
    output logic [NUM_TASKS-1:0] mask_o
);
    logic [NUM_TASKS-1:0] mask_q;
    logic [NUM_TASKS-1:0] mask_d;

    // Per-bit sticky accumulation; a clear keeps only this cycle's strobes.
    for (genvar g = 0; g < NUM_TASKS; g++) begin : g_bit
        always_comb begin
            mask_d[g] = clear_i ? alive_i[g] : (mask_q[g] | alive_i[g]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask_o = mask_q;

    // R6
    carry_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (mask_o == $past(alive_i)));

    // R2
    sticky_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (mask_o == ($past(mask_o) | $past(alive_i))));
endmodule

// File: rtl/hb_miss_counter.sv
module hb_miss_counter #(
    parameter int MISS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    output logic [MISS_W-1:0] count_o
);
    localparam logic [MISS_W-1:0] CNT_MAX = {MISS_W{1'b1}};

    logic [MISS_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                          count_q <= '0;
        else if (inc_i && count_q != CNT_MAX) count_q <= count_q + 1'b1;
    end

    assign count_o = count_q;

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == CNT_MAX) |=> (count_o == CNT_MAX));

    // R9
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && count_o != CNT_MAX) |=> (count_o == $past(count_o) + 1'b1));

    // R9
    no_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(count_o));
endmodule

// File: rtl/hb_aggregator.sv
module hb_aggregator
    import hb_pkg::*;
#(
    parameter int NUM_TASKS = 4,
    parameter int MISS_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TASKS-1:0] alive_i,
    input  logic [NUM_TASKS-1:0] enable_i,
    input  logic                 tick_i,
    output logic                 feed_o,
    output logic [NUM_TASKS-1:0] missing_o,
    output logic [MISS_W-1:0]    miss_count_o
);
    hb_state_e            state_q, state_d;
    logic [NUM_TASKS-1:0] mask;
    logic [NUM_TASKS-1:0] absent;
    logic [NUM_TASKS-1:0] missing_q;
    logic                 all_in;
    logic                 pass_clear;
    logic                 fail_inc;

    assign absent     = enable_i & ~mask;
    assign all_in     = (absent == '0);
    assign pass_clear = tick_i && all_in;
    assign fail_inc   = tick_i && !all_in;

    hb_mask_accum #(.NUM_TASKS(NUM_TASKS)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .alive_i (alive_i),
        .clear_i (pass_clear),
        .mask_o  (mask)
    );

    hb_miss_counter #(.MISS_W(MISS_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (fail_inc),
        .count_o (miss_count_o)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLLECT, ST_FEED, ST_MISS: begin
                if (tick_i) state_d = all_in ? ST_FEED : ST_MISS;
                else        state_d = ST_COLLECT;
            end
            default: state_d = ST_COLLECT;
        endcase
    end

    // State register and latched missing vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_COLLECT;
            missing_q <= '0;
        end else begin
            state_q <= state_d;
            if (tick_i) missing_q <= absent;
        end
    end

    // Output process
    always_comb begin
        feed_o    = (state_q == ST_FEED);
        missing_o = missing_q;
    end

    // R3
    feed_after_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && ((mask & enable_i) == enable_i)) |=> feed_o);

    // R3
    feed_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        feed_o |-> $past(tick_i));

    // R5
    miss_no_feed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && ((mask & enable_i) != enable_i)) |=> (!feed_o && miss_count_o != '0));

    // R7
    missing_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (missing_o == $past(enable_i & ~mask)));

    // R10
    idle_collect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> (state_q == ST_COLLECT && !feed_o));
endmodule

// File: tb/hb_aggregator_bench.sv
module hb_aggregator_bench;
    localparam int N = 4;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] alive = '0;
    logic [N-1:0] en = '0;
    logic         tick = 1'b0;
    logic         feed;
    logic [N-1:0] missing;
    logic [W-1:0] mcount;

    int tests = 0;
    int fails = 0;

    // Reference state
    int m_mask = 0;
    int m_missing = 0;
    int m_count = 0;
    int m_feed = 0;

    always #4 clk = ~clk;

    hb_aggregator #(.NUM_TASKS(N), .MISS_W(W)) u_hb_aggregator (
        .clk          (clk),
        .rst_n        (rst_n),
        .alive_i      (alive),
        .enable_i     (en),
        .tick_i       (tick),
        .feed_o       (feed),
        .missing_o    (missing),
        .miss_count_o (mcount)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare(input string req);
        check(req, int'(feed), m_feed, "feed");
        check(req, int'(missing), m_missing, "missing");
        check(req, int'(mcount), m_count, "miss_count");
    endtask

    // One clock: drive inputs, advance the reference, compare after the edge.
    task automatic step(input int a, input int e, input int t, input string req);
        int enab;
        int absent;
        alive = a[N-1:0];
        en    = e[N-1:0];
        tick  = t[0];
        @(posedge clk);
        enab   = e & ((1 << N) - 1);
        absent = enab & ~m_mask;
        m_feed = 0;
        if (t != 0) begin
            m_missing = absent;
            if (absent == 0) begin
                m_feed = 1;
                m_mask = a;
            end else begin
                m_mask = m_mask | a;
                if (m_count < (1 << W) - 1) m_count++;
            end
        end else begin
            m_mask = m_mask | a;
        end
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        compare("R1");
        rst_n = 1'b1;
        step(0, 15, 0, "R10");
        step(0, 15, 0, "R10");

        // R2/R3: strobes in separate cycles accumulate, then feed one cycle
        step(1, 15, 0, "R2");
        step(2, 15, 0, "R2");
        step(0, 15, 0, "R10");
        step(4, 15, 0, "R2");
        step(8, 15, 0, "R2");
        step(0, 15, 1, "R3");
        step(0, 15, 0, "R3");

        // R4: mask cleared after feed, next tick misses everything
        step(0, 15, 1, "R4");
        step(0, 15, 0, "R7");

        // R5/R7: task 3 missing; mask kept, late strobe then passes
        step(7, 15, 0, "R5");
        step(0, 15, 1, "R7");
        step(0, 15, 0, "R5");
        step(8, 15, 0, "R5");
        step(0, 15, 1, "R5");
        step(0, 15, 0, "R7");

        // R6: strobes in the tick cycle carry into the new period
        step(15, 15, 0, "R6");
        step(15, 15, 1, "R6");
        step(0, 15, 0, "R6");
        step(0, 15, 1, "R6");
        step(0, 15, 1, "R6");
        step(2, 15, 1, "R6");
        step(0, 15, 0, "R7");

        // R8: disabled tasks ignored
        step(0, 5, 0, "R8");
        step(5, 5, 0, "R8");
        step(0, 5, 0, "R8");
        step(0, 5, 1, "R8");
        step(0, 5, 0, "R8");
        step(0, 5, 1, "R8");
        step(0, 0, 0, "R8");
        step(0, 0, 1, "R8");
        step(0, 0, 1, "R8");
        step(0, 0, 0, "R8");

        // R9: saturation of the miss counter
        step(0, 15, 0, "R9");
        for (int i = 0; i < 260; i++) step(0, 15, 1, "R9");
        step(0, 15, 0, "R9");
        step(0, 15, 1, "R9");
        step(0, 15, 0, "R9");

        // R1: reset again clears outputs
        rst_n = 1'b0;
        @(posedge clk);
        m_mask = 0; m_missing = 0; m_count = 0; m_feed = 0;
        @(negedge clk);
        compare("R1");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule